// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-data and output-enable path of a synchronous burst SRAM behavioural core. Each rising clock edge samples a command: a chip selection made from two enables, plus a write flag. When the array has data for a read, it presents that data with a valid strobe in the cycle after the command edge. A static mode input chooses how the data reaches the pins. In flow-through mode the array data is passed straight to the data bus. In pipelined mode the data is first captured by a rising-edge output register, which adds one clock of latency (three clocks to the first beat instead of two).

Deselect commands travel down the same pipeline as reads. The drivers therefore switch off at the same depth at which read data would have appeared, and data already in flight is still delivered. When no new command is strobed, the last command stays in force: a burst keeps reading, and a deselected device stays deselected. A new command may be strobed on every cycle. An active-low output enable and a write command on the current cycle both switch the drive off combinationally. The bus is driven to zero whenever the drive enable is low.

Top module: `sram_rd_out`

## Requirements
- R1: While reset is asserted and after it is released with no command, dq_oe is 0 and dq_out is all zeros.
- R2: A strobed command selects the chip only when ce_n is 0 and ce is 1. Any other combination of the two enables is a deselect.
- R3: With pipe_mode 0, in a cycle that follows a selected read command edge, dq_out equals rd_data combinationally whenever rd_vld is 1.
- R4: With pipe_mode 1, rd_data presented with rd_vld in the cycle after a read command edge is captured at the next edge. It is driven on dq_out for the whole following cycle.
- R5: An edge where cmd_valid is 0 keeps the previous command in force, so reads continue beat by beat. A new command is accepted on every edge where cmd_valid is 1, with no stall.
- R6: With pipe_mode 1, dq_oe stays 1 for the cycle after a deselect edge, delivering the last read beat, and is 0 after the following edge.
- R7: With pipe_mode 0, dq_oe is 0 from the deselect edge onward.
- R8: dq_oe is 0 in any cycle where cmd_valid is 1, the chip is selected and wr is 1, whatever the pipeline holds. Write commands never cause drive.
- R9: oe_n at 1 forces dq_oe to 0 in the same cycle, without waiting for a clock edge.
- R10: dq_out is all zeros whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A new command is strobed at this edge |
| ce_n | input | 1 | Primary chip enable, active low |
| ce | input | 1 | Secondary chip enable, active high |
| wr | input | 1 | Command is a write |
| rd_vld | input | 1 | Array read data is valid this cycle |
| rd_data | input | DW | Array read data |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through; an undriven value acts as 1 |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | DW | Data bus value, zero when not driven |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Back-to-back reads followed by a deselect are run in both modes. This separates the two-edge turn-off of pipelined mode from the one-edge turn-off of flow-through mode, and shows whether the last beat in flight is still delivered. Enable pairs with only one of the two enables active check that a half selection is a deselect. Writes issued while a read is in the output stage, and oe_n pulses, check that the combinational overrides win over registered state. Long random runs in each mode mix strobed and held commands with gaps in rd_vld and are compared against a bench model, which exposes latency or hold errors.

// File: rtl/sram_rd_out.sv
module sram_rd_out #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          ce_n,
  input  logic          ce,
  input  logic          wr,
  input  logic          rd_vld,
  input  logic [DW-1:0] rd_data,
  input  logic          pipe_mode,
  input  logic          oe_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  typedef enum logic [1:0] {K_IDLE, K_RD, K_WR, K_DS} kind_t;

  kind_t         s1_kind;
  kind_t         s1_next;
  logic          s2_rd;
  logic [DW-1:0] q_reg;
  logic          sel;
  logic          wr_now;
  logic          pipe_en;
  logic          s1_rd;
  logic          src_on;

  assign sel     = ~ce_n & ce;
  assign wr_now  = cmd_valid & sel & wr;
  assign pipe_en = (pipe_mode !== 1'b0);
  assign s1_rd   = (s1_kind == K_RD);

  always_comb begin
    s1_next = s1_kind;
    if (cmd_valid) begin
      if (!sel)    s1_next = K_DS;
      else if (wr) s1_next = K_WR;
      else         s1_next = K_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_kind <= K_IDLE;
      s2_rd   <= 1'b0;
      q_reg   <= '0;
    end else begin
      s1_kind <= s1_next;
      s2_rd   <= s1_rd & rd_vld;
      if (s1_rd & rd_vld) q_reg <= rd_data;
    end
  end

  assign src_on = pipe_en ? s2_rd : (s1_rd & rd_vld);
  assign dq_oe  = src_on & ~oe_n & ~wr_now;
  assign dq_out = dq_oe ? (pipe_en ? q_reg : rd_data) : '0;

endmodule

module sram_rd_out_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          ce_n,
  input logic          ce,
  input logic          wr,
  input logic          rd_vld,
  input logic [DW-1:0] rd_data,
  input logic          pipe_mode,
  input logic          oe_n,
  input logic          s1_rd,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  a_r8_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ce_n && ce && wr) |-> !dq_oe);

  a_r7_ft_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(cmd_valid && !(!ce_n && ce))) |-> !dq_oe);

  a_r6_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && $past(cmd_valid && !(!ce_n && ce), 2) && !$past(cmd_valid))
      |-> !dq_oe);

  a_r4_pipe_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && $past(s1_rd && rd_vld) && dq_oe) |-> (dq_out == $past(rd_data)));

  a_r3_ft_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_rd && rd_vld && !oe_n && !(cmd_valid && !ce_n && ce && wr))
      |-> (dq_oe && dq_out == rd_data));

endmodule

bind sram_rd_out sram_rd_out_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ce_n(ce_n), .ce(ce),
  .wr(wr), .rd_vld(rd_vld), .rd_data(rd_data), .pipe_mode(pipe_mode),
  .oe_n(oe_n), .s1_rd(s1_rd), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sram_rd_out_test.sv
`timescale 1ns/1ps
module sram_rd_out_test;
  localparam int DW = 36;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_valid = 0, ce_n = 1, ce = 0, wr = 0, rd_vld = 0;
  logic [DW-1:0] rd_data = '0;
  logic          pipe_mode = 1, oe_n = 0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int vecs = 0;
  int errs = 0;

  // bench model state: 0 idle, 1 read, 2 write, 3 deselect
  int            m1 = 0;
  bit            m2v = 0;
  logic [DW-1:0] m2d = '0;

  always #2.5 clk = ~clk;

  sram_rd_out #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ce_n(ce_n), .ce(ce),
    .wr(wr), .rd_vld(rd_vld), .rd_data(rd_data), .pipe_mode(pipe_mode),
    .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic bit exp_oe();
    bit on;
    on = pipe_mode ? m2v : (m1 == 1 && rd_vld);
    return on && !oe_n && !(cmd_valid && !ce_n && ce && wr);
  endfunction

  function automatic logic [DW-1:0] exp_dq();
    if (!exp_oe()) return '0;
    return pipe_mode ? m2d : rd_data;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m1 = 0; m2v = 0; m2d = '0;
    end else begin
      if (m1 == 1 && rd_vld) m2d = rd_data;
      m2v = (m1 == 1) && rd_vld;
      if (cmd_valid) m1 = (!ce_n && ce) ? (wr ? 2 : 1) : 3;
    end
  endtask

  task automatic step(input bit cv, input bit cen, input bit cep, input bit w,
                      input bit rv, input logic [DW-1:0] d, input bit oen, input string tag);
    @(negedge clk);
    cmd_valid = cv; ce_n = cen; ce = cep; wr = w; rd_vld = rv; rd_data = d; oe_n = oen;
    #1;
    chk({tag, " oe"}, DW'(dq_oe), DW'(exp_oe()));
    chk({tag, " dq"}, dq_out, exp_dq());
    @(posedge clk);
    #0.5;
    model_edge();
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 0; pipe_mode = mode;
    cmd_valid = 0; ce_n = 1; ce = 0; wr = 0; rd_vld = 0; oe_n = 0;
    repeat (2) @(posedge clk);
    #0.5;
    model_edge();
    chk("R1 oe in reset", DW'(dq_oe), '0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      bit cv, cen, cep, w, rv, oen;
      cv  = ($urandom_range(0, 1) == 1);
      cen = ($urandom_range(0, 4) == 0);
      cep = ($urandom_range(0, 4) != 0);
      w   = ($urandom_range(0, 3) == 0);
      rv  = (m1 == 1) ? ($urandom_range(0, 6) != 0) : ($urandom_range(0, 9) == 0);
      oen = ($urandom_range(0, 9) == 0);
      step(cv, cen, cep, w, rv, {$urandom, $urandom}, oen, tag);
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));

    // pipelined mode
    do_reset(1);
    step(0, 1, 0, 0, 0, '0, 0, "R1");
    step(1, 0, 1, 0, 0, '0, 0, "R2 read cmd");
    step(0, 0, 1, 0, 1, 36'h0_1111_1111, 0, "R5 hold beat0");
    chk("R4 first beat", dq_out, 36'h0_1111_1111);
    step(0, 0, 1, 0, 1, 36'h0_2222_2222, 0, "R5 hold beat1");
    chk("R4 second beat", dq_out, 36'h0_2222_2222);
    step(1, 1, 1, 0, 1, 36'h0_3333_3333, 0, "R6 deselect edge");
    chk("R6 last beat on", DW'(dq_oe), 1);
    chk("R6 last beat data", dq_out, 36'h0_3333_3333);
    step(0, 1, 1, 0, 0, '0, 0, "R6 after");
    chk("R6 off after second edge", DW'(dq_oe), 0);
    step(1, 0, 0, 0, 0, '0, 0, "R2 half select");
    step(0, 0, 0, 0, 1, 36'h0_4444_4444, 0, "R2 half select hold");
    chk("R2 half select no drive", DW'(dq_oe), 0);
    step(1, 0, 1, 0, 0, '0, 0, "R5 read");
    step(1, 0, 1, 0, 1, 36'h0_5555_5555, 0, "R5 read again");
    step(1, 0, 1, 1, 1, 36'h0_6666_6666, 0, "R8 write over valid beat");
    step(0, 0, 1, 0, 0, '0, 1, "R9 oe_n high");
    chk("R10 bus zero", dq_out, '0);
    rand_run(3000, "R4");

    // flow-through mode
    do_reset(0);
    step(0, 1, 0, 0, 0, '0, 0, "R1");
    step(1, 0, 1, 0, 0, '0, 0, "R2 read cmd");
    step(0, 0, 1, 0, 1, 36'h0_7777_7777, 0, "R3 beat0");
    step(1, 1, 1, 0, 1, 36'h0_8888_8888, 0, "R7 deselect cycle");
    chk("R7 off after deselect edge", DW'(dq_oe), 0);
    step(0, 1, 1, 0, 1, 36'h0_9999_9999, 0, "R7 stays off");
    step(1, 0, 1, 0, 0, '0, 0, "R3 read");
    step(0, 0, 1, 0, 1, 36'h0_aaaa_aaaa, 1, "R9 oe_n high");
    step(1, 0, 1, 1, 1, 36'h0_bbbb_bbbb, 0, "R8 write");
    rand_run(3000, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule